// File: doc/BRIEF.md
# Double-Buffered PWM Action Control Registers

This block holds the action-control words for two PWM outputs, A and B. Each output has its own pair of registers. Software writes the shadow copy and the active copy drives a small action stage. That stage sets, clears or toggles the output when the timebase reports a counter event. Each channel can also run in immediate mode, where software writes straight into the active copy. This lets software prepare a new action pattern at any time and have it take effect at a clean point in the PWM period.

In double-buffered mode the shadow word is copied into the active copy on a load event chosen per channel. The load event can be a counter-zero tick, a counter-period tick, either of those, or none. A channel can also load on an external sync pulse. A channel can instead follow a global-load strobe that is shared with other blocks. When a compare value of zero makes an action event fall on the same tick as a counter-zero load, the action uses the active word from before the load. The new word takes effect from the next tick.

Software reaches the block over a small register bus. Reads have one cycle of latency. The active words are also driven out on read-only ports.

Top module: `pwm_aq_shadow_top`

## Requirements
- R1: After a synchronous reset, both channels are in immediate mode, all configuration, shadow and active words are zero, and both PWM outputs are low.
- R2: The configuration word is at address 0 and has these bits: bit 0 enables double buffering for A and bit 1 for B, bits [3:2] hold the load mode of A and bits [5:4] that of B, bit 6 enables the sync load for A and bit 7 for B, bit 8 selects global load for A and bit 9 for B. The two channels' enables are independent.
- R3: In immediate mode, a write to the channel's address (1 for A, 2 for B) appears on the active port on the next cycle. A read of that address returns the active word. Read data appears one cycle after the address is presented.
- R4: In double-buffered mode, a write goes to the shadow word only, a read returns the shadow word, and the active word holds until a load event.
- R5: Load mode 00 loads on counter zero, 01 on counter period, 10 on either, and 11 never from the counter. Counter events count only in a cycle where ctr_tick is high.
- R6: When the channel's sync-load bit is set and global load is not selected, a sync_in pulse also loads the shadow into the active word.
- R7: When global load is selected for a double-buffered channel, only gld_strobe loads it; counter events and sync_in have no effect on it.
- R8: If a load and a write to the same channel fall in one cycle, the active word takes the old shadow value and the shadow takes the written value.
- R9: An action triggered in the same tick as a load is decided by the active word from before the load.
- R10: Each event has a 2-bit action field: 00 none, 01 clear, 10 set, 11 toggle. The fields are at bits [1:0] for zero, [3:2] for period, [5:4] for compare A counting up, [7:6] for compare A counting down, [9:8] for compare B counting up and [11:10] for compare B counting down. The output changes one cycle after the tick.
- R11: When several events come in one tick, only the highest one acts. The order from high to low is compare B, compare A, period, zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ctr_tick | input | 1 | Counter advanced this cycle; qualifies all events |
| ev_zero | input | 1 | Counter equals zero |
| ev_prd | input | 1 | Counter equals period |
| ev_cmpa | input | 1 | Counter equals compare A |
| ev_cmpb | input | 1 | Counter equals compare B |
| cnt_up | input | 1 | Counting direction, 1 = up |
| sync_in | input | 1 | External sync pulse |
| gld_strobe | input | 1 | Shared global-load strobe |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| act_a | output | DATA_W | Active action word of A |
| act_b | output | DATA_W | Active action word of B |

## Verification
Some behaviours are checked by assertions on every cycle. These are the immediate-mode write reaching the active word, the active word holding between loads, a load copying the shadow, a global-mode channel ignoring everything but the strobe, and each action code driving the output to its set, clear or toggle value. Other behaviours can only be shown by the bench's scenarios, where a reference model follows a seeded random run and directed cases. These are the choice of load event for each mode, the write-and-load collision, the priority among simultaneous events, the use of the pre-load word when an action and a load fall in the same tick, and what each read returns.

// File: rtl/aq_pkg.sv
package aq_pkg;
  localparam int N_EV  = 6;
  localparam int ACT_W = 2 * N_EV;
  localparam int CFG_W = 10;

  localparam int EV_ZRO = 0;
  localparam int EV_PRD = 1;
  localparam int EV_CAU = 2;
  localparam int EV_CAD = 3;
  localparam int EV_CBU = 4;
  localparam int EV_CBD = 5;

  localparam logic [1:0] ADR_CFG = 2'd0;
  localparam logic [1:0] ADR_A   = 2'd1;
  localparam logic [1:0] ADR_B   = 2'd2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    LD_ZERO = 2'b00,
    LD_PRD  = 2'b01,
    LD_BOTH = 2'b10,
    LD_FRZ  = 2'b11
  } ldmode_e;

  typedef struct packed {
    logic    glb;
    logic    sync_en;
    ldmode_e mode;
    logic    shd_en;
  } chcfg_t;
endpackage

// File: rtl/aq_load_sel.sv
module aq_load_sel
  import aq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  chcfg_t cfg,
  input  logic   ctr_tick,
  input  logic   ev_zero,
  input  logic   ev_prd,
  input  logic   sync_in,
  input  logic   gld_strobe,
  output logic   load
);
  logic ctr_hit;

  always_comb begin
    unique case (cfg.mode)
      LD_ZERO: ctr_hit = ctr_tick & ev_zero;
      LD_PRD:  ctr_hit = ctr_tick & ev_prd;
      LD_BOTH: ctr_hit = ctr_tick & (ev_zero | ev_prd);
      default: ctr_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!cfg.shd_en)   load = 1'b0;
    else if (cfg.glb)  load = gld_strobe;
    else               load = ctr_hit | (cfg.sync_en & sync_in);
  end

  // R7: a global-mode channel loads only on the shared strobe
  p_glb_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (load && cfg.glb) |-> gld_strobe);
  // R5: no counter event reaches the load without a tick
  p_no_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !ctr_tick && !cfg.glb) |-> (cfg.sync_en && sync_in));
endmodule

// File: rtl/aq_shadow_reg.sv
module aq_shadow_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shd_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active,
  output logic [W-1:0] shadow,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      shadow <= '0;
    end else if (!shd_en) begin
      if (wr) active <= wdata;
    end else begin
      if (load) active <= shadow;
      if (wr)   shadow <= wdata;
    end
  end

  assign rd_val = shd_en ? shadow : active;

  // R3: immediate write lands in the active copy next cycle
  p_imm_write_r3: assert property (@(posedge clk) disable iff (rst)
    (!shd_en && wr) |=> (active == $past(wdata)));
  // R4: buffered active word holds without a load
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (shd_en && !load) |=> $stable(active));
  // R8: a load copies the pre-edge shadow even with a write in flight
  p_load_copy_r8: assert property (@(posedge clk) disable iff (rst)
    (shd_en && load) |=> (active == $past(shadow)));
endmodule

// File: rtl/aq_action.sv
module aq_action
  import aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ACT_W-1:0] word,
  input  logic             ctr_tick,
  input  logic             ev_zero,
  input  logic             ev_prd,
  input  logic             ev_cmpa,
  input  logic             ev_cmpb,
  input  logic             cnt_up,
  output logic             pwm
);
  act_e code;
  int   idx;

  always_comb begin
    idx = -1;
    if (ctr_tick) begin
      if (ev_cmpb)      idx = cnt_up ? EV_CBU : EV_CBD;
      else if (ev_cmpa) idx = cnt_up ? EV_CAU : EV_CAD;
      else if (ev_prd)  idx = EV_PRD;
      else if (ev_zero) idx = EV_ZRO;
    end
    code = (idx < 0) ? ACT_NONE : act_e'(word[2*idx +: 2]);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else begin
      unique case (code)
        ACT_CLR: pwm <= 1'b0;
        ACT_SET: pwm <= 1'b1;
        ACT_TGL: pwm <= ~pwm;
        default: pwm <= pwm;
      endcase
    end
  end

  // R10: each code drives the output as specified
  p_set_r10: assert property (@(posedge clk) disable iff (rst)
    (code == ACT_SET) |=> pwm);
  p_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (code == ACT_CLR) |=> !pwm);
  p_tgl_r10: assert property (@(posedge clk) disable iff (rst)
    (code == ACT_TGL) |=> (pwm != $past(pwm)));
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ctr_tick |=> $stable(pwm));
endmodule

// File: rtl/pwm_aq_shadow_top.sv
module pwm_aq_shadow_top
  import aq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = aq_pkg::ACT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ctr_tick,
  input  logic              ev_zero,
  input  logic              ev_prd,
  input  logic              ev_cmpa,
  input  logic              ev_cmpb,
  input  logic              cnt_up,
  input  logic              sync_in,
  input  logic              gld_strobe,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [DATA_W-1:0] act_a,
  output logic [DATA_W-1:0] act_b
);
  localparam int NCH = 2;

  logic [CFG_W-1:0]  cfg_q;
  chcfg_t            ch_cfg [NCH];
  logic [ACT_W-1:0]  active [NCH];
  logic [ACT_W-1:0]  shadow [NCH];
  logic [ACT_W-1:0]  rd_val [NCH];
  logic              pwm    [NCH];
  logic              load   [NCH];

  always_ff @(posedge clk) begin
    if (rst)                                              cfg_q <= '0;
    else if (bus_we && bus_addr == ADDR_W'(ADR_CFG))      cfg_q <= bus_wdata[CFG_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c;

    assign ch_cfg[c].shd_en  = cfg_q[c];
    assign ch_cfg[c].mode    = ldmode_e'(cfg_q[2+2*c +: 2]);
    assign ch_cfg[c].sync_en = cfg_q[6+c];
    assign ch_cfg[c].glb     = cfg_q[8+c];
    assign wr_c = bus_we && (bus_addr == ADDR_W'(c + 1));

    aq_load_sel u_sel (
      .clk(clk), .rst(rst), .cfg(ch_cfg[c]), .ctr_tick(ctr_tick),
      .ev_zero(ev_zero), .ev_prd(ev_prd), .sync_in(sync_in),
      .gld_strobe(gld_strobe), .load(load[c])
    );

    aq_shadow_reg #(.W(ACT_W)) u_reg (
      .clk(clk), .rst(rst), .shd_en(ch_cfg[c].shd_en), .wr(wr_c),
      .wdata(bus_wdata[ACT_W-1:0]), .load(load[c]),
      .active(active[c]), .shadow(shadow[c]), .rd_val(rd_val[c])
    );

    aq_action u_act (
      .clk(clk), .rst(rst), .word(active[c]), .ctr_tick(ctr_tick),
      .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmpa(ev_cmpa),
      .ev_cmpb(ev_cmpb), .cnt_up(cnt_up), .pwm(pwm[c])
    );

    // R7: global-mode channel is deaf to counter and sync without the strobe
    p_glb_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (ch_cfg[c].shd_en && ch_cfg[c].glb && !gld_strobe) |=> $stable(active[c]));
    // R4: buffered write changes only the shadow copy
    p_shadow_wr_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_cfg[c].shd_en && wr_c) |=> (shadow[c] == $past(bus_wdata[ACT_W-1:0])));
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        ADDR_W'(ADR_CFG): bus_rdata <= DATA_W'(cfg_q);
        ADDR_W'(ADR_A):   bus_rdata <= DATA_W'(rd_val[0]);
        ADDR_W'(ADR_B):   bus_rdata <= DATA_W'(rd_val[1]);
        default:          bus_rdata <= '0;
      endcase
    end
  end

  assign pwm_a = pwm[0];
  assign pwm_b = pwm[1];
  assign act_a = DATA_W'(active[0]);
  assign act_b = DATA_W'(active[1]);
endmodule

// File: tb/pwm_aq_shadow_top_test.sv
module pwm_aq_shadow_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic        ctr_tick = 0, ev_zero = 0, ev_prd = 0, ev_cmpa = 0, ev_cmpb = 0;
  logic        cnt_up = 1, sync_in = 0, gld_strobe = 0;
  logic        pwm_a, pwm_b;
  logic [11:0] act_a, act_b;

  int total = 0;
  int bad = 0;

  logic [9:0]  m_cfg;
  logic [11:0] m_sh [2];
  logic [11:0] m_ac [2];
  logic        m_out [2];
  logic [11:0] m_rd;

  always #5 clk = ~clk;

  pwm_aq_shadow_top uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctr_tick(ctr_tick),
    .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb),
    .cnt_up(cnt_up), .sync_in(sync_in), .gld_strobe(gld_strobe),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .act_a(act_a), .act_b(act_b)
  );

  task automatic chk(input string req, input logic [11:0] actual, input logic [11:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  // load decision per R5, R6, R7
  function automatic logic f_load(input int c);
    logic       shd = m_cfg[c];
    logic [1:0] md  = m_cfg[2+2*c +: 2];
    logic       cnt;
    if (!shd) return 1'b0;
    if (m_cfg[8+c]) return gld_strobe;
    cnt = ctr_tick && ((md == 2'b00 && ev_zero) || (md == 2'b01 && ev_prd) ||
                       (md == 2'b10 && (ev_zero || ev_prd)));
    return cnt || (m_cfg[6+c] && sync_in);
  endfunction

  // action code per R10, R11
  function automatic logic [1:0] f_code(input logic [11:0] w);
    if (!ctr_tick) return 2'b00;
    if (ev_cmpb) return cnt_up ? w[9:8] : w[11:10];
    if (ev_cmpa) return cnt_up ? w[5:4] : w[7:6];
    if (ev_prd)  return w[3:2];
    if (ev_zero) return w[1:0];
    return 2'b00;
  endfunction

  function automatic logic f_apply(input logic o, input logic [1:0] cd);
    case (cd)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~o;
      default: return o;
    endcase
  endfunction

  task automatic model_reset();
    m_cfg = '0; m_rd = '0;
    for (int c = 0; c < 2; c++) begin m_sh[c] = '0; m_ac[c] = '0; m_out[c] = 1'b0; end
  endtask

  task automatic model_step();
    logic [11:0] nsh [2];
    logic [11:0] nac [2];
    logic        ld, wr;
    case (bus_addr)
      2'd0: m_rd = {2'b00, m_cfg};
      2'd1: m_rd = m_cfg[0] ? m_sh[0] : m_ac[0];
      2'd2: m_rd = m_cfg[1] ? m_sh[1] : m_ac[1];
      default: m_rd = '0;
    endcase
    for (int c = 0; c < 2; c++) begin
      ld = f_load(c);
      wr = bus_we && (bus_addr == 2'(c + 1));
      m_out[c] = f_apply(m_out[c], f_code(m_ac[c]));
      nsh[c] = m_sh[c]; nac[c] = m_ac[c];
      if (!m_cfg[c]) begin
        if (wr) nac[c] = bus_wdata;
      end else begin
        if (ld) nac[c] = m_sh[c];
        if (wr) nsh[c] = bus_wdata;
      end
    end
    for (int c = 0; c < 2; c++) begin m_sh[c] = nsh[c]; m_ac[c] = nac[c]; end
    if (bus_we && bus_addr == 2'd0) m_cfg = bus_wdata[9:0];
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model_step();
    chk("R4 model act_a", act_a, m_ac[0]);
    chk("R4 model act_b", act_b, m_ac[1]);
    chk("R10 model pwm_a", {11'd0, pwm_a}, {11'd0, m_out[0]});
    chk("R10 model pwm_b", {11'd0, pwm_b}, {11'd0, m_out[1]});
    chk("R3 model rdata", bus_rdata, m_rd);
  endtask

  task automatic idle();
    bus_we = 0; bus_addr = 0; bus_wdata = 0; ctr_tick = 0; ev_zero = 0;
    ev_prd = 0; ev_cmpa = 0; ev_cmpb = 0; cnt_up = 1; sync_in = 0; gld_strobe = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d; cyc(); idle();
  endtask

  task automatic rd(input logic [1:0] a);
    bus_addr = a; cyc(); idle();
  endtask

  // tick with events {cmpb, cmpa, prd, zero}
  task automatic tk(input logic [3:0] ev, input logic up);
    ctr_tick = 1; {ev_cmpb, ev_cmpa, ev_prd, ev_zero} = ev; cnt_up = up; cyc(); idle();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rd(2'd0);
    chk("R1 cfg", bus_rdata, 12'h000);
    chk("R1 act_a", act_a, 12'h000);
    chk("R1 pwm", {10'd0, pwm_a, pwm_b}, 12'h000);
    // R3 immediate write and read-back
    wr(2'd1, 12'h0A5);
    chk("R3 act_a", act_a, 12'h0A5);
    rd(2'd1);
    chk("R3 read active", bus_rdata, 12'h0A5);
    // R2 buffer A only; B stays immediate
    wr(2'd0, 12'h001);
    wr(2'd2, 12'h03C);
    chk("R2 B immediate", act_b, 12'h03C);
    wr(2'd1, 12'h111);
    chk("R4 A held", act_a, 12'h0A5);
    rd(2'd1);
    chk("R4 read shadow", bus_rdata, 12'h111);
    // R5 mode 00: period and untick'd zero do not load
    tk(4'b0010, 1);
    chk("R5 prd ignored", act_a, 12'h0A5);
    ev_zero = 1; cyc(); idle();
    chk("R5 no tick", act_a, 12'h0A5);
    tk(4'b0001, 1);
    chk("R5 zero load", act_a, 12'h111);
    // R5 mode 11 freeze
    wr(2'd0, 12'h00D);
    wr(2'd1, 12'h222);
    tk(4'b0011, 1);
    chk("R5 freeze", act_a, 12'h111);
    // R6 sync load
    wr(2'd0, 12'h04D);
    sync_in = 1; cyc(); idle();
    chk("R6 sync load", act_a, 12'h222);
    // R7 global load
    wr(2'd0, 12'h141);
    wr(2'd1, 12'h333);
    tk(4'b0001, 1);
    sync_in = 1; cyc(); idle();
    chk("R7 ignored", act_a, 12'h222);
    gld_strobe = 1; cyc(); idle();
    chk("R7 strobe", act_a, 12'h333);
    // R8 write and load in same cycle
    wr(2'd0, 12'h001);
    wr(2'd1, 12'h444);
    bus_we = 1; bus_addr = 2'd1; bus_wdata = 12'h555; ctr_tick = 1; ev_zero = 1;
    cyc(); idle();
    chk("R8 active old shadow", act_a, 12'h444);
    rd(2'd1);
    chk("R8 shadow new", bus_rdata, 12'h555);
    // R9 contention: zero action with pre-load word
    wr(2'd0, 12'h000);
    wr(2'd1, 12'h001);
    tk(4'b0001, 1);
    chk("R9 setup clear", {11'd0, pwm_a}, 12'h000);
    wr(2'd0, 12'h001);
    wr(2'd1, 12'h002);
    tk(4'b0001, 1);
    chk("R9 old word used", {11'd0, pwm_a}, 12'h000);
    chk("R9 loaded", act_a, 12'h002);
    tk(4'b0001, 1);
    chk("R9 new word next", {11'd0, pwm_a}, 12'h001);
    // R10 toggle on compare A up, down field empty
    wr(2'd0, 12'h000);
    wr(2'd1, 12'h030);
    tk(4'b0100, 1);
    chk("R10 toggle", {11'd0, pwm_a}, 12'h000);
    tk(4'b0100, 0);
    chk("R10 down none", {11'd0, pwm_a}, 12'h000);
    tk(4'b0100, 1);
    chk("R10 toggle back", {11'd0, pwm_a}, 12'h001);
    // R11 compare B beats zero
    wr(2'd1, 12'h102);
    tk(4'b1001, 1);
    chk("R11 priority", {11'd0, pwm_a}, 12'h000);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      bus_we     = ($urandom % 4) == 0;
      bus_addr   = 2'($urandom % 4);
      bus_wdata  = 12'($urandom);
      ctr_tick   = $urandom % 2;
      ev_zero    = ($urandom % 4) == 0;
      ev_prd     = ($urandom % 4) == 0;
      ev_cmpa    = ($urandom % 4) == 0;
      ev_cmpb    = ($urandom % 4) == 0;
      cnt_up     = $urandom % 2;
      sync_in    = ($urandom % 10) == 0;
      gld_strobe = ($urandom % 10) == 0;
      cyc();
    end
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule